// File: doc/BRIEF.md
# Secondary Low-Frequency Oscillator Controller

This block controls a slow secondary clock source, such as a 32 kHz watch crystal, inside a clock subsystem. A 2-bit configuration field picks one of three modes. Two are crystal modes: one drives the crystal harder, and the other drives it with less power at the cost of a longer start-up. The third is a digital mode, in which the oscillator pins are handed over to general-purpose I/O, the crystal driver stays off, and an external clock-input pin feeds every consumer of the secondary clock directly.

In the crystal modes the oscillator runs whenever anything needs it. That can be a software enable, which lets firmware start the crystal early and hide the start-up delay, or any one of a set of peripheral request lines, such as a real-time clock or a timer. The analog start-up is replaced by a cycle counter. Its length depends on the drive mode, and it restarts whenever the run request drops or the crystal mode changes. After the count expires the block raises a ready flag, and the gated clock output begins producing whole pulses. It never emits a partial pulse.

The `clk` input stands for the raw crystal oscillation. Every count in this block is a count of its rising edges.

Top module: `sosc_ctrl`

## Requirements
- R1: With `cfg_sel` = 00 (digital mode), `pins_gpio_en` is 1, `xtal_drive_en` is 0 and `sosc_ready` is 1. `sw_enable` and `periph_req` have no effect on any of these outputs.
- R2: With `cfg_sel` = 01, 10 or 11 (crystal modes), `pins_gpio_en` is 0.
- R3: The run request is `sw_enable` OR any bit of `periph_req`. `xtal_drive_en` is 1 exactly when a crystal mode is selected and the run request is present.
- R4: In high-drive mode (`cfg_sel` = 11, and reserved 10, which behaves the same), `sosc_ready` rises at the HD_CYCLES-th rising edge of `clk` at which the run request is sampled high. Switching between 11 and 10 does not restart the count.
- R5: In low-power mode (`cfg_sel` = 01), `sosc_ready` rises after LP_CYCLES edges instead. `xtal_lowpwr` is 1 exactly when `cfg_sel` = 01.
- R6: A rising edge of `clk` at which the run request is low clears `sosc_ready` in crystal modes. A later request counts the full start-up again from zero.
- R7: A change of crystal drive mode, or a change from digital mode to a crystal mode, clears the count at the next edge. Start-up then takes one edge more than the mode's count.
- R8: In digital mode `sosc_clk` equals `ext_clk_in`. In crystal modes `sosc_clk` is low during every low phase of `clk`. It copies the high phase of `clk` only once ready has been captured at the falling edge of `clk` before that phase.
- R9: Synchronous active-high `rst` clears the start-up count and the crystal ready state.
- R10: While the run request stays high and the mode is unchanged, a change of which source supplies the request (software or a peripheral) leaves `sosc_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Raw crystal oscillation; clocks the start-up model |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 2 | Mode select: 00 digital, 01 low-power crystal, 11 high-drive crystal, 10 reserved (as 11) |
| sw_enable | input | 1 | Software enable, used to pre-start the crystal |
| periph_req | input | NUM_REQ | On-demand requests from peripherals |
| ext_clk_in | input | 1 | External clock-input pin, used in digital mode |
| sosc_clk | output | 1 | Secondary clock delivered to consumers |
| sosc_ready | output | 1 | Secondary clock is valid |
| pins_gpio_en | output | 1 | Oscillator pins released to digital I/O |
| xtal_drive_en | output | 1 | Crystal driver enabled |
| xtal_lowpwr | output | 1 | Crystal driver in low drive strength |

## Verification
The bench builds the block with HD_CYCLES = 8, LP_CYCLES = 20 and NUM_REQ = 3. With these values, every start-up, restart and mode change completes within a few dozen cycles. Each corner is then compared against a behavioural model on every clock: the count boundary in both drive modes, a mode change mid-count, a request drop one cycle after ready, and a return from digital mode. The gated clock is sampled in both phases of each cycle, which exposes any partial or early pulse.

// File: rtl/sosc_pkg.sv
package sosc_pkg;

    // Operating mode of the secondary source after decoding the select field.
    typedef enum logic [1:0] {
        SOSC_DIGITAL = 2'd0,
        SOSC_LOWPWR  = 2'd1,
        SOSC_HIGHDRV = 2'd2
    } sosc_mode_e;

    // Decoded configuration carried between sub-blocks.
    typedef struct packed {
        sosc_mode_e mode;
        logic       pins_digital;
        logic       xtal_allowed;
        logic       low_drive;
    } sosc_cfg_t;

    // Select field decode; reserved 2'b10 falls into the high-drive branch.
    function automatic sosc_mode_e decode_mode(input logic [1:0] sel);
        sosc_mode_e m;
        unique case (sel)
            2'b00:   m = SOSC_DIGITAL;
            2'b01:   m = SOSC_LOWPWR;
            default: m = SOSC_HIGHDRV;
        endcase
        return m;
    endfunction

    function automatic sosc_cfg_t build_cfg(input sosc_mode_e m);
        sosc_cfg_t c;
        c.mode         = m;
        c.pins_digital = (m == SOSC_DIGITAL);
        c.xtal_allowed = (m != SOSC_DIGITAL);
        c.low_drive    = (m == SOSC_LOWPWR);
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sosc_mode_decode.sv
module sosc_mode_decode
    import sosc_pkg::*;
(
    input  logic [1:0] cfg_sel,
    output sosc_cfg_t  cfg
);

    always_comb begin
        cfg = build_cfg(decode_mode(cfg_sel));
    end

endmodule

// File: rtl/sosc_run_request.sv
module sosc_run_request
    import sosc_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4
) (
    input  sosc_cfg_t           cfg,
    input  logic                sw_enable,
    input  logic [NUM_REQ-1:0]  periph_req,
    output logic                run_req
);

    // OR chain across the request lines, one stage per requester.
    logic [NUM_REQ:0] any_chain;

    assign any_chain[0] = sw_enable;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req_or
        assign any_chain[g+1] = any_chain[g] | periph_req[g];
    end

    // In digital mode the crystal never runs, whatever is requesting it.
    assign run_req = any_chain[NUM_REQ] & cfg.xtal_allowed;

endmodule

// File: rtl/sosc_startup_timer.sv
module sosc_startup_timer
    import sosc_pkg::*;
#(
    parameter int unsigned HD_CYCLES = 1024,
    parameter int unsigned LP_CYCLES = 4096
) (
    input  logic      clk,
    input  logic      rst,
    input  sosc_cfg_t cfg,
    input  logic      run_req,
    output logic      osc_ready
);

    localparam int unsigned MAX_CYCLES = max_u(HD_CYCLES, LP_CYCLES);
    localparam int unsigned CNT_W      = $clog2(MAX_CYCLES) + 1;
    localparam logic [CNT_W-1:0] HD_LAST = CNT_W'(HD_CYCLES - 1);
    localparam logic [CNT_W-1:0] LP_LAST = CNT_W'(LP_CYCLES - 1);

    logic [CNT_W-1:0] settle_cnt;
    logic [CNT_W-1:0] last_value;
    sosc_mode_e       mode_q;
    logic             mode_changed;

    always_comb begin
        last_value   = cfg.low_drive ? LP_LAST : HD_LAST;
        mode_changed = (cfg.mode != mode_q);
    end

    // Mode history is kept through reset so the first edge after reset
    // does not see a spurious change.
    always_ff @(posedge clk) begin
        mode_q <= cfg.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= '0;
            osc_ready  <= 1'b0;
        end else if (!run_req || mode_changed) begin
            settle_cnt <= '0;
            osc_ready  <= 1'b0;
        end else if (!osc_ready) begin
            if (settle_cnt == last_value) begin
                osc_ready <= 1'b1;
            end else begin
                settle_cnt <= settle_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sosc_clk_gate.sv
module sosc_clk_gate
    import sosc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sosc_cfg_t cfg,
    input  logic      osc_ready,
    input  logic      ext_clk_in,
    output logic      sosc_clk
);

    logic gate_en;
    logic xtal_gated;

    // Enable captured while the clock is low, so it never cuts a high phase.
    always_ff @(negedge clk) begin
        if (rst) begin
            gate_en <= 1'b0;
        end else begin
            gate_en <= osc_ready;
        end
    end

    assign xtal_gated = clk & gate_en;
    assign sosc_clk   = cfg.pins_digital ? ext_clk_in : xtal_gated;

endmodule

// File: rtl/sosc_ctrl.sv
module sosc_ctrl
    import sosc_pkg::*;
#(
    parameter int unsigned NUM_REQ   = 4,
    parameter int unsigned HD_CYCLES = 1024,
    parameter int unsigned LP_CYCLES = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_sel,
    input  logic               sw_enable,
    input  logic [NUM_REQ-1:0] periph_req,
    input  logic               ext_clk_in,
    output logic               sosc_clk,
    output logic               sosc_ready,
    output logic               pins_gpio_en,
    output logic               xtal_drive_en,
    output logic               xtal_lowpwr
);

    sosc_cfg_t cfg;
    logic      run_req;
    logic      osc_ready;

    sosc_mode_decode u_decode (
        .cfg_sel (cfg_sel),
        .cfg     (cfg)
    );

    sosc_run_request #(
        .NUM_REQ (NUM_REQ)
    ) u_request (
        .cfg        (cfg),
        .sw_enable  (sw_enable),
        .periph_req (periph_req),
        .run_req    (run_req)
    );

    sosc_startup_timer #(
        .HD_CYCLES (HD_CYCLES),
        .LP_CYCLES (LP_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .run_req   (run_req),
        .osc_ready (osc_ready)
    );

    sosc_clk_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .osc_ready  (osc_ready),
        .ext_clk_in (ext_clk_in),
        .sosc_clk   (sosc_clk)
    );

    assign sosc_ready    = cfg.pins_digital | osc_ready;
    assign pins_gpio_en  = cfg.pins_digital;
    assign xtal_drive_en = run_req;
    assign xtal_lowpwr   = cfg.low_drive;

endmodule

// File: rtl/sosc_ctrl_checker.sv
module sosc_ctrl_checker #(
    parameter int unsigned NUM_REQ   = 4,
    parameter int unsigned HD_CYCLES = 1024,
    parameter int unsigned LP_CYCLES = 4096
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         cfg_sel,
    input logic               sw_enable,
    input logic [NUM_REQ-1:0] periph_req,
    input logic               sosc_ready,
    input logic               pins_gpio_en,
    input logic               xtal_drive_en,
    input logic               xtal_lowpwr,
    input logic               run_req,
    input logic               osc_ready
);

    localparam int unsigned RUN_W = $clog2((HD_CYCLES > LP_CYCLES) ? HD_CYCLES : LP_CYCLES) + 2;

    logic [RUN_W-1:0] run_len;
    logic             lp_prev;
    logic             lp_now;

    assign lp_now = (cfg_sel == 2'b01);

    always_ff @(posedge clk) begin
        lp_prev <= lp_now;
        if (rst || !run_req) begin
            run_len <= '0;
        end else if (run_len != {RUN_W{1'b1}}) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_digital_mode_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel == 2'b00) |-> (pins_gpio_en && sosc_ready && !xtal_drive_en));

    assert_xtal_pins_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel != 2'b00) |-> !pins_gpio_en);

    assert_drive_follows_request_R3: assert property (@(posedge clk) disable iff (rst)
        ((cfg_sel != 2'b00) && (sw_enable || (|periph_req))) |-> xtal_drive_en);

    assert_min_startup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_ready) |-> (run_len >= RUN_W'(HD_CYCLES)));

    assert_lp_startup_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(osc_ready) && lp_prev) |-> (run_len >= RUN_W'(LP_CYCLES)));

    assert_lowpwr_flag_R5: assert property (@(posedge clk) disable iff (rst)
        xtal_lowpwr == lp_now);

    assert_drop_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !run_req |=> !osc_ready);

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (osc_ready && run_req && (lp_now == lp_prev)) |=> osc_ready);

endmodule

bind sosc_ctrl sosc_ctrl_checker #(
    .NUM_REQ   (NUM_REQ),
    .HD_CYCLES (HD_CYCLES),
    .LP_CYCLES (LP_CYCLES)
) u_checker (
    .clk           (clk),
    .rst           (rst),
    .cfg_sel       (cfg_sel),
    .sw_enable     (sw_enable),
    .periph_req    (periph_req),
    .sosc_ready    (sosc_ready),
    .pins_gpio_en  (pins_gpio_en),
    .xtal_drive_en (xtal_drive_en),
    .xtal_lowpwr   (xtal_lowpwr),
    .run_req       (run_req),
    .osc_ready     (osc_ready)
);

// File: tb/sosc_ctrl_tb_top.sv
module sosc_ctrl_tb_top;

    localparam int NREQ = 3;
    localparam int HD   = 8;
    localparam int LP   = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      cfg_sel = 2'b11;
    logic            sw_enable = 1'b0;
    logic [NREQ-1:0] periph_req = '0;
    logic            ext_clk_in = 1'b0;
    logic            sosc_clk;
    logic            sosc_ready;
    logic            pins_gpio_en;
    logic            xtal_drive_en;
    logic            xtal_lowpwr;

    int n_checks = 0;
    int n_errors = 0;
    bit cmp_on   = 1'b0;
    bit finished = 1'b0;

    // Behavioural reference state
    int m_cnt  = 0;
    bit m_rdy  = 1'b0;
    int m_prev = 2;
    bit gate_m = 1'b0;

    always #5 clk = ~clk;

    sosc_ctrl #(
        .NUM_REQ   (NREQ),
        .HD_CYCLES (HD),
        .LP_CYCLES (LP)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_sel       (cfg_sel),
        .sw_enable     (sw_enable),
        .periph_req    (periph_req),
        .ext_clk_in    (ext_clk_in),
        .sosc_clk      (sosc_clk),
        .sosc_ready    (sosc_ready),
        .pins_gpio_en  (pins_gpio_en),
        .xtal_drive_en (xtal_drive_en),
        .xtal_lowpwr   (xtal_lowpwr)
    );

    function automatic int mode_of(input logic [1:0] s);
        if (s == 2'b00) return 0;
        if (s == 2'b01) return 1;
        return 2;
    endfunction

    task automatic check(input string tag, input logic actual, input logic expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, actual, expected, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        int  md;
        bit  req;
        int  lim;
        md  = mode_of(cfg_sel);
        req = sw_enable || (|periph_req);
        lim = (md == 1) ? LP : HD;
        if (rst || md == 0 || !req || md != m_prev) begin
            m_cnt = 0;
            m_rdy = 1'b0;
        end else if (!m_rdy) begin
            m_cnt++;
            if (m_cnt == lim) m_rdy = 1'b1;
        end
        m_prev = md;
    end

    always @(negedge clk) begin
        gate_m = rst ? 1'b0 : m_rdy;
    end

    // Per-cycle comparison: high phase then low phase.
    initial begin
        wait (cmp_on);
        forever begin
            @(posedge clk);
            #2;
            begin
                int md;
                bit req;
                md  = mode_of(cfg_sel);
                req = sw_enable || (|periph_req);
                check("R4/R5/R6/R7 ready", sosc_ready, (md == 0) ? 1'b1 : m_rdy);
                check("R1/R2 gpio", pins_gpio_en, md == 0);
                check("R3 drive", xtal_drive_en, (md != 0) && req);
                check("R5 lowpwr", xtal_lowpwr, md == 1);
                check("R8 clk high", sosc_clk, (md == 0) ? ext_clk_in : gate_m);
            end
            @(negedge clk);
            #1;
            check("R8 clk low", sosc_clk, (mode_of(cfg_sel) == 0) ? ext_clk_in : 1'b0);
        end
    end

    // External clock pin toggles away from all sample points.
    initial begin
        forever begin
            @(posedge clk);
            #8;
            ext_clk_in = ~ext_clk_in;
        end
    end

    // Leaves the bench 3 ns after the n-th coming rising edge.
    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        adv(3);
        check("R9 reset ready", sosc_ready, 1'b0);
        rst = 1'b0;
        cmp_on = 1'b1;
        adv(2);
        check("R3 idle no drive", xtal_drive_en, 1'b0);

        // R4: high-drive start-up on a peripheral request
        periph_req = 3'b010;
        adv(HD - 1);
        check("R4 not ready before count", sosc_ready, 1'b0);
        adv(1);
        check("R4 ready at count", sosc_ready, 1'b1);
        adv(2);
        check("R8 clk passes high", sosc_clk, 1'b1);

        // R6: drop and restart
        periph_req = '0;
        adv(1);
        check("R6 ready cleared", sosc_ready, 1'b0);
        sw_enable = 1'b1;
        adv(HD - 1);
        check("R6 restart from zero", sosc_ready, 1'b0);
        adv(1);
        check("R6 ready after restart", sosc_ready, 1'b1);

        // R4: reserved 10 acts as 11 without restart
        cfg_sel = 2'b10;
        adv(3);
        check("R4 reserved keeps ready", sosc_ready, 1'b1);
        sw_enable = 1'b0;
        adv(1);
        periph_req = 3'b100;
        adv(HD - 1);
        check("R4 reserved count low", sosc_ready, 1'b0);
        adv(1);
        check("R4 reserved count done", sosc_ready, 1'b1);
        periph_req = '0;

        // R5: low-power start-up
        cfg_sel = 2'b01;
        adv(2);
        sw_enable = 1'b1;
        adv(LP - 1);
        check("R5 lp not ready", sosc_ready, 1'b0);
        check("R5 lp flag", xtal_lowpwr, 1'b1);
        adv(1);
        check("R5 lp ready", sosc_ready, 1'b1);

        // R10: request source handover keeps ready
        periph_req = 3'b001;
        adv(1);
        sw_enable = 1'b0;
        adv(4);
        check("R10 handover keeps ready", sosc_ready, 1'b1);
        periph_req = '0;
        adv(2);

        // R7: mode change mid-count restarts
        cfg_sel = 2'b11;
        sw_enable = 1'b1;
        adv(5);
        cfg_sel = 2'b01;
        adv(LP);
        check("R7 restart after mode change", sosc_ready, 1'b0);
        adv(1);
        check("R7 ready after mode change", sosc_ready, 1'b1);

        // R1: digital mode ignores enables
        cfg_sel = 2'b00;
        adv(1);
        check("R1 digital ready", sosc_ready, 1'b1);
        check("R1 digital gpio", pins_gpio_en, 1'b1);
        check("R1 digital no drive", xtal_drive_en, 1'b0);
        sw_enable = 1'b0;
        periph_req = 3'b111;
        adv(3);
        check("R1 requests ignored", xtal_drive_en, 1'b0);
        periph_req = '0;
        sw_enable = 1'b1;
        adv(3);

        // R7: digital to crystal with request already high
        cfg_sel = 2'b11;
        adv(HD);
        check("R7 from digital not ready", sosc_ready, 1'b0);
        adv(1);
        check("R7 from digital ready", sosc_ready, 1'b1);

        // R9: reset in the middle of operation
        rst = 1'b1;
        adv(1);
        check("R9 reset clears ready", sosc_ready, 1'b0);
        rst = 1'b0;
        adv(HD);
        check("R9 count after reset", sosc_ready, 1'b1);
        adv(4);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule